// File: doc/BRIEF.md
# Embedded Card Bring-Up Order Checker

This block watches a stream of already-decoded host commands and device responses on an embedded storage card link and confirms that the host brings the card up in the required order. The order is reset (index 0), operating-condition polling (index 1), identification (index 2), relative-address assignment (index 3) and card select (index 7). The block also watches a busy indication from the device. It flags a host that issues the next command before the device has left its busy state.

The first departure from the required order is latched as a step code together with the offending 6-bit command index, and it stays until reset. A reset command at any point before completion starts the check again from the polling step. Once the select command is answered with a clean short status response, the block reports completion and ignores everything that follows.

The state machine has these states: ST_WAIT_RESET, ST_WAIT_OPCOND, ST_OPCOND_RSP, ST_WAIT_CID, ST_CID_RSP, ST_WAIT_ADDR, ST_ADDR_RSP, ST_WAIT_SEL, ST_SEL_RSP, ST_DONE and ST_FAULT. The transitions are as follows:
- **go**: the expected command is seen in a wait state, with busy low. The machine moves to the matching response state.
- **restart**: index 0 is seen in any wait or response state. The machine moves to ST_WAIT_OPCOND.
- **poll**: a not-ready response to index 1 is seen. The machine moves from ST_OPCOND_RSP back to ST_WAIT_OPCOND.
- **advance**: an accepted response is seen. The machine moves to the next wait state, or to ST_DONE after the select response.
- **fault**: a departure is seen. The machine moves to ST_FAULT.

Top module: `init_seq_checker`

## Requirements
- R1: After reset, seq_done and seq_err are 0, and err_step and err_idx are 0.
- R2: The events idx 0, idx 1 (ready response), idx 2 (long response), idx 3 (response), idx 7 (short response with the error flag clear) drive seq_done to 1 on the clock edge that samples the last response.
- R3: Index 1 may be repeated while its response has rsp_ready=0. A command of index 2 is accepted only after a response with rsp_ready=1. If index 2 comes before that, the block faults with err_step=1 and err_idx=2.
- R4: A command other than index 0 that differs from the expected index of the current step sets seq_err. It also latches the step code (0=reset, 1=polling, 2=identify, 3=address, 4=select) and the offending index.
- R5: A command other than index 0 that is issued while dev_busy=1 in a wait state is a fault at that step, even if the index is the expected one.
- R6: Index 0 in any state other than ST_DONE and ST_FAULT restarts the check at the polling step, without raising seq_err.
- R7: If the identification response has rsp_long=0, the block faults with err_step=2 and err_idx=2.
- R8: If the select response has rsp_err=1 or rsp_long=1, the block faults with err_step=4 and err_idx=7.
- R9: A command other than index 0 that arrives while a response is awaited is a fault at that step, carrying that command's index.
- R10: seq_err, err_step and err_idx stay unchanged after a fault, whatever events follow, including index 0.
- R11: After seq_done rises, later commands and responses change no output.
- R12: A response that arrives while no command is awaiting one has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A decoded host command is present this cycle |
| cmd_idx | input | 6 | Index of that command |
| dev_busy | input | 1 | Device is holding its busy indication |
| rsp_valid | input | 1 | A decoded device response is present this cycle |
| rsp_ready | input | 1 | Ready bit carried in a polling response |
| rsp_long | input | 1 | Response uses the long (identification) form |
| rsp_err | input | 1 | Status response reports an error |
| seq_done | output | 1 | Bring-up completed in order |
| seq_err | output | 1 | A departure was found (sticky) |
| err_step | output | 3 | Step code at which the departure occurred |
| err_idx | output | 6 | Command index of the departure |

## Verification
The hardest situations to reach are a restart deep in the sequence and a fault on the select response. Each needs a fully legal prefix of commands and responses, including at least one not-ready poll, before the point under test. The bench therefore builds every scenario from short task calls that replay a correct prefix and then inject one deviation: a busy-gated command, an early command, a wrong response form or a mid-sequence reset. A behavioural model holds the expected outputs, and they are compared on every clock.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;

    typedef enum logic [3:0] {
        ST_WAIT_RESET,
        ST_WAIT_OPCOND,
        ST_OPCOND_RSP,
        ST_WAIT_CID,
        ST_CID_RSP,
        ST_WAIT_ADDR,
        ST_ADDR_RSP,
        ST_WAIT_SEL,
        ST_SEL_RSP,
        ST_DONE,
        ST_FAULT
    } seq_state_t;

endpackage

// File: rtl/init_seq_expect.sv
module init_seq_expect #(
    parameter int IDX_W     = 6,
    parameter int STEP_W    = 3,
    parameter int NUM_STEPS = 5,
    parameter logic [NUM_STEPS*IDX_W-1:0] CMD_ORDER = {6'd7, 6'd3, 6'd2, 6'd1, 6'd0}
) (
    input  logic [STEP_W-1:0] step_i,
    output logic [IDX_W-1:0]  idx_o
);
    logic [IDX_W-1:0] order_tbl [NUM_STEPS];

    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_tbl
        assign order_tbl[g] = CMD_ORDER[g*IDX_W +: IDX_W];
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_STEPS; i++) begin
            if (step_i == i[STEP_W-1:0]) idx_o = order_tbl[i];
        end
    end
endmodule

// File: rtl/init_seq_fault_reg.sv
module init_seq_fault_reg #(
    parameter int IDX_W  = 6,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [STEP_W-1:0] step_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic held_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            step_o <= '0;
            idx_o  <= '0;
        end else if (set_i && !held_q) begin
            held_q <= 1'b1;
            step_o <= step_i;
            idx_o  <= idx_i;
        end
    end

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held_q |=> held_q && $stable(step_o) && $stable(idx_o));
endmodule

// File: rtl/init_seq_checker.sv
module init_seq_checker
    import init_seq_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int STEP_W    = 3,
    parameter int NUM_STEPS = 5,
    parameter logic [NUM_STEPS*IDX_W-1:0] CMD_ORDER = {6'd7, 6'd3, 6'd2, 6'd1, 6'd0}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic              dev_busy,
    input  logic              rsp_valid,
    input  logic              rsp_ready,
    input  logic              rsp_long,
    input  logic              rsp_err,
    output logic              seq_done,
    output logic              seq_err,
    output logic [STEP_W-1:0] err_step,
    output logic [IDX_W-1:0]  err_idx
);
    localparam logic [IDX_W-1:0] RESET_IDX = CMD_ORDER[IDX_W-1:0];

    seq_state_t        state_q, state_d;
    logic [STEP_W-1:0] cur_step;
    logic [IDX_W-1:0]  exp_idx;
    logic              flt_set;
    logic [IDX_W-1:0]  flt_idx;
    logic              is_reset_cmd;

    // step code for each state
    always_comb begin
        unique case (state_q)
            ST_WAIT_OPCOND, ST_OPCOND_RSP: cur_step = STEP_W'(1);
            ST_WAIT_CID,    ST_CID_RSP:    cur_step = STEP_W'(2);
            ST_WAIT_ADDR,   ST_ADDR_RSP:   cur_step = STEP_W'(3);
            ST_WAIT_SEL,    ST_SEL_RSP:    cur_step = STEP_W'(4);
            default:                       cur_step = '0;
        endcase
    end

    init_seq_expect #(
        .IDX_W(IDX_W), .STEP_W(STEP_W), .NUM_STEPS(NUM_STEPS), .CMD_ORDER(CMD_ORDER)
    ) u_expect (
        .step_i(cur_step),
        .idx_o (exp_idx)
    );

    assign is_reset_cmd = cmd_valid && (cmd_idx == RESET_IDX);

    // next-state logic
    always_comb begin
        state_d = state_q;
        flt_set = 1'b0;
        flt_idx = cmd_valid ? cmd_idx : exp_idx;
        unique case (state_q)
            ST_WAIT_RESET, ST_WAIT_OPCOND, ST_WAIT_CID, ST_WAIT_ADDR, ST_WAIT_SEL: begin
                if (is_reset_cmd) begin
                    state_d = ST_WAIT_OPCOND;
                end else if (cmd_valid) begin
                    if (dev_busy || cmd_idx != exp_idx || state_q == ST_WAIT_RESET) begin
                        flt_set = 1'b1;
                    end else begin
                        unique case (state_q)
                            ST_WAIT_OPCOND: state_d = ST_OPCOND_RSP;
                            ST_WAIT_CID:    state_d = ST_CID_RSP;
                            ST_WAIT_ADDR:   state_d = ST_ADDR_RSP;
                            ST_WAIT_SEL:    state_d = ST_SEL_RSP;
                            default:        state_d = state_q;
                        endcase
                    end
                end
            end
            ST_OPCOND_RSP, ST_CID_RSP, ST_ADDR_RSP, ST_SEL_RSP: begin
                if (is_reset_cmd) begin
                    state_d = ST_WAIT_OPCOND;
                end else if (cmd_valid) begin
                    flt_set = 1'b1;
                end else if (rsp_valid) begin
                    unique case (state_q)
                        ST_OPCOND_RSP: state_d = rsp_ready ? ST_WAIT_CID : ST_WAIT_OPCOND;
                        ST_CID_RSP: begin
                            if (rsp_long) state_d = ST_WAIT_ADDR;
                            else          flt_set = 1'b1;
                        end
                        ST_ADDR_RSP: state_d = ST_WAIT_SEL;
                        ST_SEL_RSP: begin
                            if (!rsp_long && !rsp_err) state_d = ST_DONE;
                            else                       flt_set = 1'b1;
                        end
                        default: state_d = state_q;
                    endcase
                end
            end
            ST_DONE, ST_FAULT: state_d = state_q;
            default:           state_d = ST_FAULT;
        endcase
        if (flt_set) state_d = ST_FAULT;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT_RESET;
        else        state_q <= state_d;
    end

    init_seq_fault_reg #(.IDX_W(IDX_W), .STEP_W(STEP_W)) u_fault (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flt_set),
        .step_i(cur_step),
        .idx_i (flt_idx),
        .step_o(err_step),
        .idx_o (err_idx)
    );

    // outputs
    always_comb begin
        seq_done = (state_q == ST_DONE);
        seq_err  = (state_q == ST_FAULT);
    end

    // R2
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_done) |-> $past(rsp_valid) && !$past(rsp_err) && !$past(rsp_long));

    // R11
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> seq_done && !seq_err);

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err && !seq_done);

    // R4
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> err_step <= STEP_W'(4));

    // R6
    restart_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_reset_cmd && !seq_done && !seq_err |=> !seq_err && !seq_done);

    // R5
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !is_reset_cmd && dev_busy && !seq_done && !seq_err
        && state_q != ST_WAIT_RESET |=> seq_err);
endmodule

// File: tb/tb_init_seq_checker.sv
`timescale 1ns/1ps
module tb_init_seq_checker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [5:0] cmd_idx = '0;
    logic       dev_busy = 1'b0;
    logic       rsp_valid = 1'b0;
    logic       rsp_ready = 1'b0;
    logic       rsp_long = 1'b0;
    logic       rsp_err = 1'b0;
    logic       seq_done, seq_err;
    logic [2:0] err_step;
    logic [5:0] err_idx;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;
    string cur_req = "R1";

    // behavioural reference model
    int order_q[$] = '{0, 1, 2, 3, 7};
    int m_stage, m_wait, m_done, m_err, m_step, m_idx;

    always #2.5 clk = ~clk;

    init_seq_checker dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
        .dev_busy(dev_busy), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_long(rsp_long), .rsp_err(rsp_err), .seq_done(seq_done),
        .seq_err(seq_err), .err_step(err_step), .err_idx(err_idx)
    );

    function automatic void m_fault(int st, int ix);
        m_err = 1; m_step = st; m_idx = ix;
    endfunction

    function automatic void m_reset();
        m_stage = 0; m_wait = 0; m_done = 0; m_err = 0; m_step = 0; m_idx = 0;
    endfunction

    function automatic void m_cmd(int ix, bit busy);
        if (m_err != 0 || m_done != 0) return;
        if (ix == 0) begin m_stage = 1; m_wait = 0; end
        else if (m_wait != 0) m_fault(m_stage, ix);
        else if (m_stage == 0 || busy || ix != order_q[m_stage]) m_fault(m_stage, ix);
        else m_wait = 1;
    endfunction

    function automatic void m_rsp(bit rdy, bit lng, bit er);
        if (m_err != 0 || m_done != 0 || m_wait == 0) return;
        m_wait = 0;
        case (m_stage)
            1: if (rdy) m_stage = 2;
            2: if (lng) m_stage = 3; else m_fault(2, 2);
            3: m_stage = 4;
            4: if (!lng && !er) m_done = 1; else m_fault(4, 7);
            default: ;
        endcase
    endfunction

    task automatic compare();
        checks++;
        if (seq_done !== m_done[0] || seq_err !== m_err[0] ||
            err_step !== m_step[2:0] || err_idx !== m_idx[5:0]) begin
            failures++;
            $display("FAIL %s: done/err/step/idx actual %0b/%0b/%0d/%0d expected %0d/%0d/%0d/%0d",
                     cur_req, seq_done, seq_err, err_step, err_idx, m_done, m_err, m_step, m_idx);
        end
    endtask

    task automatic finish_cycle();
        @(posedge clk); #1;
        cmd_valid = 0; rsp_valid = 0; dev_busy = 0;
        rsp_ready = 0; rsp_long = 0; rsp_err = 0;
        compare();
    endtask

    task automatic send_cmd(int ix, bit busy = 0);
        cmd_valid = 1; cmd_idx = 6'(ix); dev_busy = busy;
        m_cmd(ix, busy);
        finish_cycle();
    endtask

    task automatic send_rsp(bit rdy, bit lng, bit er);
        rsp_valid = 1; rsp_ready = rdy; rsp_long = lng; rsp_err = er;
        m_rsp(rdy, lng, er);
        finish_cycle();
    endtask

    task automatic idle();
        finish_cycle();
    endtask

    task automatic do_reset();
        rst_n = 0; m_reset();
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1;
        compare();
    endtask

    task automatic prefix_to_sel();
        send_cmd(0); send_cmd(1); send_rsp(0, 0, 0);
        send_cmd(1); send_rsp(1, 0, 0);
        send_cmd(2); send_rsp(0, 1, 0);
        send_cmd(3); send_rsp(0, 0, 0);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        cur_req = "R1"; do_reset(); idle();

        cur_req = "R2"; prefix_to_sel(); send_cmd(7); send_rsp(0, 0, 0);
        cur_req = "R11"; send_cmd(5); send_cmd(0); send_rsp(0, 0, 1); idle();

        cur_req = "R4"; do_reset(); send_cmd(0); send_cmd(2);
        cur_req = "R10"; send_cmd(0); send_cmd(1); send_rsp(1, 1, 0); idle();

        cur_req = "R4"; do_reset(); send_cmd(5);
        do_reset(); prefix_to_sel(); send_cmd(9);

        cur_req = "R3"; do_reset(); send_cmd(0); send_cmd(1); send_rsp(0, 0, 0);
        send_cmd(1); send_rsp(0, 0, 0); send_cmd(2);

        cur_req = "R5"; do_reset(); send_cmd(0); send_cmd(1); send_rsp(1, 0, 0);
        send_cmd(2, 1);
        do_reset(); send_cmd(0, 1); send_cmd(1);

        cur_req = "R6"; do_reset(); send_cmd(0); send_cmd(1); send_rsp(1, 0, 0);
        send_cmd(2); send_rsp(0, 1, 0); send_cmd(0);
        send_cmd(1); send_rsp(1, 0, 0); send_cmd(2); send_cmd(0, 1);
        prefix_to_sel(); send_cmd(7); send_rsp(0, 0, 0);

        cur_req = "R7"; do_reset(); send_cmd(0); send_cmd(1); send_rsp(1, 0, 0);
        send_cmd(2); send_rsp(0, 0, 0);

        cur_req = "R8"; do_reset(); prefix_to_sel(); send_cmd(7); send_rsp(0, 0, 1);
        do_reset(); prefix_to_sel(); send_cmd(7); send_rsp(0, 1, 0);

        cur_req = "R9"; do_reset(); send_cmd(0); send_cmd(1); send_cmd(1);
        do_reset(); prefix_to_sel(); send_cmd(7); send_cmd(13);

        cur_req = "R12"; do_reset(); send_rsp(1, 1, 0); send_cmd(0);
        send_rsp(1, 0, 0); send_cmd(1); send_rsp(1, 0, 0);
        send_rsp(0, 0, 1); send_cmd(2); send_rsp(0, 1, 0); idle();

        report();
    end
endmodule